// File: doc/BRIEF.md
# Two-of-four weight sparsity codec

This block turns a dense group of four 16-bit weights into a fixed-size sparse record. It keeps the two weights with the largest magnitude and treats the other two as zero. The record holds the two kept values and the lane index of each. A second, independent path takes such a record and rebuilds the four-lane dense group, with zeros in the two lanes the record does not name.

Because every record has the same size, a consumer can fetch and process a group as two value/index pairs instead of four dense values. This doubles the number of useful operands per beat.

Both paths are valid/ready streams that move one group per beat. Each path has a single registered output stage, so a result appears one cycle after its input is accepted. Back-pressure stalls the stage without losing data.

Top module: `sparse24_codec`

## Requirements
- R1: After a synchronous reset, `cmp_out_valid` and `exp_out_valid` are low, and `cmp_in_ready` and `exp_in_ready` are high.
- R2: The compressor keeps the two lanes whose magnitude is largest, and passes each kept value through unchanged, sign bit included. Magnitude is bits [14:0] of a weight. Lane p of `cmp_in_group` is bits [16p+15:16p].
- R3: When magnitudes are equal, the lower lane index ranks higher.
- R4: When a group holds two or more zero-magnitude entries, every nonzero entry is kept. The remaining slots are filled by the zero-magnitude entries in the lowest lanes.
- R5: Record layout is as follows. Bits [15:0] hold the value from the lower kept lane and bits [31:16] the value from the higher kept lane. Bits [33:32] hold the lower lane index and bits [35:34] the higher one. The lower index is always strictly less than the higher one.
- R6: The expander writes bits [15:0] of `exp_in_rec` to the lane named by bits [33:32], and bits [31:16] to the lane named by bits [35:34]. It drives zero on the other lanes. No more than two output lanes are ever nonzero.
- R7: Expanding a compressor record reproduces the pruned group exactly: the kept lanes hold their original values and the pruned lanes are zero.
- R8: With the output ready held high, each path accepts a group on every cycle. Each result is valid in the cycle after its input was accepted.
- R9: While an output is valid and not ready, its data stays stable and the matching input ready is low. No accepted group is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in_valid | input | 1 | Dense group offered to the compressor |
| cmp_in_ready | output | 1 | Compressor can take a group |
| cmp_in_group | input | 64 | Four dense weights, lane 0 in the low bits |
| cmp_out_valid | output | 1 | Record available |
| cmp_out_ready | input | 1 | Downstream takes the record |
| cmp_out_rec | output | 36 | Sparse record |
| exp_in_valid | input | 1 | Record offered to the expander |
| exp_in_ready | output | 1 | Expander can take a record |
| exp_in_rec | input | 36 | Sparse record |
| exp_out_valid | output | 1 | Dense group available |
| exp_out_ready | input | 1 | Downstream takes the dense group |
| exp_out_group | output | 64 | Rebuilt dense group |

## Verification
The hardest cases to reach are the ones where magnitude alone does not decide the selection. These include equal magnitudes across three or four lanes, groups that are mostly zero, and a negative zero that must compete as magnitude zero but keep its sign bit. The stimulus table places exactly these patterns in selected lanes and checks the full record and the expanded group. A separate sequence stalls the compressor output while a second group waits at its input. It then releases both on the same edge to confirm hand-over without loss.

// File: rtl/sp24_pkg.sv
package sp24_pkg;
  localparam int WEIGHT_W = 16;
  localparam int GROUP_N  = 4;
  localparam int KEEP_N   = 2;
  localparam int IDX_W    = $clog2(GROUP_N);
  localparam int DENSE_W  = WEIGHT_W * GROUP_N;
  localparam int REC_W    = KEEP_N * (WEIGHT_W + IDX_W);
endpackage

// File: rtl/sp24_stage.sv
module sp24_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] data_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (in_valid && in_ready) begin
      vld_q  <= 1'b1;
      data_q <= in_data;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
    end
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/sp24_prune.sv
module sp24_prune
  import sp24_pkg::*;
#(
  parameter int W    = WEIGHT_W,
  parameter int N    = GROUP_N,
  parameter int K    = KEEP_N,
  localparam int IW  = $clog2(N),
  localparam int DW  = W * N,
  localparam int RW  = K * (W + IW)
) (
  input  logic [DW-1:0] group_i,
  output logic [RW-1:0] rec_o
);
  logic [N-1:0]   keep;
  logic [W-2:0]   mag [N];

  for (genvar g = 0; g < N; g++) begin : g_mag
    assign mag[g] = group_i[g*W +: W-1];
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      int beaten;
      beaten = 0;
      for (int j = 0; j < N; j++) begin
        if (j != i) begin
          if ((mag[j] > mag[i]) || ((mag[j] == mag[i]) && (j < i)))
            beaten = beaten + 1;
        end
      end
      keep[i] = (beaten < K);
    end
  end

  always_comb begin
    int slot;
    rec_o = '0;
    slot  = 0;
    for (int i = 0; i < N; i++) begin
      if (keep[i] && (slot < K)) begin
        rec_o[slot*W +: W]           = group_i[i*W +: W];
        rec_o[K*W + slot*IW +: IW]   = IW'(i);
        slot = slot + 1;
      end
    end
  end
endmodule

// File: rtl/sp24_expand.sv
module sp24_expand
  import sp24_pkg::*;
#(
  parameter int W    = WEIGHT_W,
  parameter int N    = GROUP_N,
  parameter int K    = KEEP_N,
  localparam int IW  = $clog2(N),
  localparam int DW  = W * N,
  localparam int RW  = K * (W + IW)
) (
  input  logic [RW-1:0] rec_i,
  output logic [DW-1:0] group_o
);
  for (genvar p = 0; p < N; p++) begin : g_lane
    always_comb begin
      group_o[p*W +: W] = '0;
      for (int s = 0; s < K; s++) begin
        if (rec_i[K*W + s*IW +: IW] == IW'(p))
          group_o[p*W +: W] = rec_i[s*W +: W];
      end
    end
  end
endmodule

// File: rtl/sparse24_codec.sv
module sparse24_codec
  import sp24_pkg::*;
#(
  parameter int W    = WEIGHT_W,
  parameter int N    = GROUP_N,
  parameter int K    = KEEP_N,
  localparam int IW  = $clog2(N),
  localparam int DW  = W * N,
  localparam int RW  = K * (W + IW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmp_in_valid,
  output logic          cmp_in_ready,
  input  logic [DW-1:0] cmp_in_group,
  output logic          cmp_out_valid,
  input  logic          cmp_out_ready,
  output logic [RW-1:0] cmp_out_rec,
  input  logic          exp_in_valid,
  output logic          exp_in_ready,
  input  logic [RW-1:0] exp_in_rec,
  output logic          exp_out_valid,
  input  logic          exp_out_ready,
  output logic [DW-1:0] exp_out_group
);
  logic [RW-1:0] rec_next;
  logic [DW-1:0] dense_next;

  sp24_prune #(.W(W), .N(N), .K(K)) prune_i (
    .group_i (cmp_in_group),
    .rec_o   (rec_next)
  );

  sp24_stage #(.W(RW)) cmp_stage_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (cmp_in_valid),
    .in_ready  (cmp_in_ready),
    .in_data   (rec_next),
    .out_valid (cmp_out_valid),
    .out_ready (cmp_out_ready),
    .out_data  (cmp_out_rec)
  );

  sp24_expand #(.W(W), .N(N), .K(K)) expand_i (
    .rec_i   (exp_in_rec),
    .group_o (dense_next)
  );

  sp24_stage #(.W(DW)) exp_stage_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (exp_in_valid),
    .in_ready  (exp_in_ready),
    .in_data   (dense_next),
    .out_valid (exp_out_valid),
    .out_ready (exp_out_ready),
    .out_data  (exp_out_group)
  );

  logic [N-1:0] lane_nz;
  for (genvar p = 0; p < N; p++) begin : g_nz
    assign lane_nz[p] = |exp_out_group[p*W +: W];
  end

  // R5
  idx_order_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_out_valid |-> (cmp_out_rec[K*W +: IW] < cmp_out_rec[K*W+IW +: IW]));

  // R6
  sparse_out_chk: assert property (@(posedge clk) disable iff (rst)
    exp_out_valid |-> ($countones(lane_nz) <= K));

  // R9
  cmp_stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_out_valid && !cmp_out_ready) |-> !cmp_in_ready);
endmodule

// File: tb/sparse24_codec_tb.sv
module sparse24_codec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  // Lane 0 in the low bits; records: {idx_hi, idx_lo, val_hi, val_lo}
  localparam logic [63:0] VIN [NV] = '{
    64'h0004_0003_0002_0001,   // R2 ascending
    64'hFFFF_0002_0006_8005,   // R2 sign ignored in ranking
    64'h0010_0010_0010_0010,   // R3 all equal
    64'h0009_0009_0009_0001,   // R3 three-way tie
    64'h0000_0123_0000_0000,   // R4 single nonzero
    64'h0000_0000_0000_0000,   // R4 all zero
    64'h0001_0000_0000_8000,   // R4 negative zero
    64'h00FF_8101_80FF_0100    // R2 R3 mixed
  };
  localparam logic [35:0] VREC [NV] = '{
    36'hE_0004_0003,
    36'hD_FFFF_0006,
    36'h4_0010_0010,
    36'h9_0009_0009,
    36'h8_0123_0000,
    36'h4_0000_0000,
    36'hC_0001_8000,
    36'h8_8101_0100
  };

  logic        clk = 0;
  logic        rst = 1;
  logic        cmp_in_valid = 0, cmp_out_ready = 1;
  logic        exp_in_valid = 0, exp_out_ready = 1;
  logic [63:0] cmp_in_group = '0;
  logic [35:0] exp_in_rec = '0;
  logic        cmp_in_ready, cmp_out_valid, exp_in_ready, exp_out_valid;
  logic [35:0] cmp_out_rec;
  logic [63:0] exp_out_group;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sparse24_codec dut_i (
    .clk(clk), .rst(rst),
    .cmp_in_valid(cmp_in_valid), .cmp_in_ready(cmp_in_ready),
    .cmp_in_group(cmp_in_group), .cmp_out_valid(cmp_out_valid),
    .cmp_out_ready(cmp_out_ready), .cmp_out_rec(cmp_out_rec),
    .exp_in_valid(exp_in_valid), .exp_in_ready(exp_in_ready),
    .exp_in_rec(exp_in_rec), .exp_out_valid(exp_out_valid),
    .exp_out_ready(exp_out_ready), .exp_out_group(exp_out_group)
  );

  function automatic logic [63:0] place(input logic [35:0] r);
    logic [63:0] g;
    g = '0;
    g[r[33:32]*16 +: 16] = r[15:0];
    g[r[35:34]*16 +: 16] = r[31:16];
    return g;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", {60'd0, cmp_out_valid, exp_out_valid, cmp_in_ready, exp_in_ready}, 64'h3);

    // Table walk: compress, check record, expand it, check dense group
    for (int k = 0; k < NV; k++) begin
      cmp_in_valid = 1; cmp_in_group = VIN[k];
      @(negedge clk);
      cmp_in_valid = 0;
      chk("R2/R3/R4 valid", {63'd0, cmp_out_valid}, 64'd1);
      chk("R5 record", {28'd0, cmp_out_rec}, {28'd0, VREC[k]});
      exp_in_valid = 1; exp_in_rec = cmp_out_rec;
      @(negedge clk);
      exp_in_valid = 0;
      chk("R7 roundtrip", exp_out_group, place(VREC[k]));
    end

    // R6 direct record
    exp_in_valid = 1; exp_in_rec = 36'h9_5555_AAAA;
    @(negedge clk);
    exp_in_valid = 0;
    chk("R6 expand", exp_out_group, 64'h0000_5555_AAAA_0000);
    @(negedge clk);

    // R8 back-to-back
    for (int k = 0; k <= NV; k++) begin
      if (k > 0) chk("R8 stream", {28'd0, cmp_out_rec}, {28'd0, VREC[k-1]});
      if (k < NV) begin
        chk("R8 ready", {63'd0, cmp_in_ready}, 64'd1);
        cmp_in_valid = 1; cmp_in_group = VIN[k];
      end else cmp_in_valid = 0;
      @(negedge clk);
    end

    // R9 back-pressure
    cmp_out_ready = 0;
    cmp_in_valid = 1; cmp_in_group = VIN[0];
    @(negedge clk);
    cmp_in_group = VIN[1];
    repeat (3) @(negedge clk);
    chk("R9 hold", {27'd0, cmp_out_valid, cmp_out_rec}, {27'd0, 1'b1, VREC[0]});
    chk("R9 ready low", {63'd0, cmp_in_ready}, 64'd0);
    cmp_out_ready = 1;
    @(negedge clk);
    cmp_in_valid = 0;
    chk("R9 handover", {27'd0, cmp_out_valid, cmp_out_rec}, {27'd0, 1'b1, VREC[1]});
    @(negedge clk);
    chk("R9 no dup", {63'd0, cmp_out_valid}, 64'd0);

    // R1 reset mid-stream
    cmp_in_valid = 1; cmp_in_group = VIN[2];
    exp_in_valid = 1; exp_in_rec = VREC[2];
    @(negedge clk);
    cmp_in_valid = 0; exp_in_valid = 0; rst = 1;
    @(negedge clk);
    chk("R1 mid reset", {62'd0, cmp_out_valid, exp_out_valid}, 64'd0);
    rst = 0;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule